// File: doc/BRIEF.md
# Overlay Pixel Unpack and Blend

This block takes one on-screen-display overlay pixel per cycle, turns it into an 8-bit-per-channel colour with an alpha level, and mixes it over the video pixel that lies underneath. A colour-format field and a container-size field say how the 32-bit overlay word is laid out. In indexed form the low byte of the word selects one of 256 palette entries. Software loads an entry in two writes: the entry number first, then the colour word.

Three transparency controls can be enabled separately or together. The first is a colour key that makes matching pixels vanish. The second is an alpha carried by each pixel, whose meaning depends on the format. The third is one alpha level that applies to the whole overlay. The combined alpha weights a rounded mix of overlay and video. The result appears two clock edges after the pixel is presented.

The palette loader is a two-state machine. In PAL_IDLE a data write is dropped. An index write moves it to PAL_ARMED (arm) and latches the entry number. In PAL_ARMED a data write stores the colour at the latched entry and returns to PAL_IDLE (commit). A further index write re-latches and stays in PAL_ARMED (re-arm). An index write takes priority over a data write in the same cycle.

Top module: `osd_blend`

## Requirements
- R1: During and after reset, out_valid and out_pixel are 0 and the palette loader is in PAL_IDLE.
- R2: A pixel presented with in_valid high in cycle N gives out_valid high with its result after the second rising edge. out_valid is low when no pixel was presented two edges earlier.
- R3: Format 3'b100 (32-bit ARGB) takes alpha from bits 31:24 and red, green and blue from bits 23:16, 15:8 and 7:0. With all transparency controls off, the output equals the overlay colour.
- R4: Format 3'b001 uses R=15:11, G=10:5, B=4:0. Each channel widens to 8 bits by repeating its top bits below it. The format has no per-pixel alpha, so it is opaque even with local alpha enabled.
- R5: Format 3'b010 uses R=14:10, G=9:5, B=4:0 with the same widening. With local alpha enabled, bit 15 = 1 makes the pixel fully transparent and bit 15 = 0 makes it opaque.
- R6: Format 3'b011 uses R=11:8, G=7:4, B=3:0, each nibble repeated. With local alpha enabled, any set bit in 15:12 makes the pixel fully transparent.
- R7: Container code 2'b01 (8-bit) forces indexed mode whatever the format field holds. Format 3'b000 also selects indexed mode in a wider container. Word bits a format does not use are padding and have no effect.
- R8: In indexed mode, the palette word gives alpha in 31:24 and RGB in 23:0. An entry changes only on a data write that follows an index write (low 8 bits of pal_wdata). A data write in PAL_IDLE changes nothing.
- R9: With keying enabled, a matching pixel is fully transparent, so the output equals the video pixel. The compared bits are 15:0 for the three 16-bit formats, 23:0 for 32-bit ARGB, and the index byte 7:0 in indexed mode, each against the same low bits of key_value.
- R10: Effective alpha a = round(l*g/255), with l = 255 when local alpha is off and g = 255 when global alpha is off. Each channel is round((o*a + v*(255-a))/255), where round adds 127 before dividing. Global alpha 0 yields the video pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 3 | Colour format code |
| cfg_bpp | input | 2 | Container size code |
| cfg_key_en | input | 1 | Colour key enable |
| cfg_local_en | input | 1 | Per-pixel alpha enable |
| cfg_global_en | input | 1 | Global alpha enable |
| key_value | input | 24 | Colour key compare value |
| global_alpha | input | 8 | Global alpha level |
| pal_idx_wr | input | 1 | Palette index write strobe |
| pal_data_wr | input | 1 | Palette data write strobe |
| pal_wdata | input | 32 | Palette write data (index in low byte, or colour word) |
| in_valid | input | 1 | Overlay/video pixel pair present |
| ovl_pixel | input | 32 | Raw overlay word |
| vid_pixel | input | 24 | Underlying video RGB |
| out_valid | output | 1 | Blended pixel present |
| out_pixel | output | 24 | Blended RGB |

## Verification
The hardest situation to reach from the ports is a stray palette data write while the loader is in PAL_IDLE. Nothing shows that write directly. The bench first loads entry 0, because the held entry number resets to 0 and a write that was wrongly accepted would land there. It then issues a lone data write and looks up entry 0 as an indexed pixel. A changed colour would expose the fault. Keying is driven with words whose padding bits differ from the key, so that the bench can show the comparison is limited to the format's own bits.

// File: rtl/osd_blend_pkg.sv
package osd_blend_pkg;

    typedef enum logic [2:0] {
        FMT_INDEX = 3'd0,
        FMT_565   = 3'd1,
        FMT_555   = 3'd2,
        FMT_444   = 3'd3,
        FMT_8888  = 3'd4
    } fmt_e;

    localparam logic [1:0] BOX_8 = 2'b01;

    typedef enum logic {
        PAL_IDLE,
        PAL_ARMED
    } pal_state_e;

    typedef struct packed {
        logic [7:0] r;
        logic [7:0] g;
        logic [7:0] b;
    } rgb_t;

endpackage

// File: rtl/osd_palette.sv
module osd_palette
    import osd_blend_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int WORD_W = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idx_wr,
    input  logic              data_wr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_word
);

    pal_state_e           state, state_n;
    logic                 commit;
    logic [IDX_W-1:0]     held_idx;
    logic [WORD_W-1:0]    table_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) state <= PAL_IDLE;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        commit  = 1'b0;
        unique case (state)
            PAL_IDLE: begin
                if (idx_wr) state_n = PAL_ARMED;
            end
            PAL_ARMED: begin
                if (idx_wr) begin
                    state_n = PAL_ARMED;
                end else if (data_wr) begin
                    commit  = 1'b1;
                    state_n = PAL_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      held_idx <= '0;
        else if (idx_wr) held_idx <= wdata[IDX_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (commit) table_q[held_idx] <= wdata;
    end

    assign rd_word = table_q[rd_idx];

endmodule

// File: rtl/osd_unpack.sv
module osd_unpack
    import osd_blend_pkg::*;
(
    input  logic [2:0]  cfg_mode,
    input  logic [1:0]  cfg_bpp,
    input  logic        cfg_key_en,
    input  logic        cfg_local_en,
    input  logic        cfg_global_en,
    input  logic [23:0] key_value,
    input  logic [7:0]  global_alpha,
    input  logic [31:0] pixel,
    input  logic [31:0] pal_word,
    output rgb_t        colour,
    output logic [7:0]  alpha
);

    logic [2:0] eff_mode;
    logic [7:0] la, l, g;
    logic       hit;

    assign eff_mode = (cfg_bpp == BOX_8) ? FMT_INDEX : cfg_mode;

    always_comb begin
        unique case (eff_mode)
            FMT_INDEX: begin
                colour = pal_word[23:0];
                la     = pal_word[31:24];
                hit    = (pixel[7:0] == key_value[7:0]);
            end
            FMT_565: begin
                colour = {pixel[15:11], pixel[15:13],
                          pixel[10:5],  pixel[10:9],
                          pixel[4:0],   pixel[4:2]};
                la     = 8'hFF;
                hit    = (pixel[15:0] == key_value[15:0]);
            end
            FMT_555: begin
                colour = {pixel[14:10], pixel[14:12],
                          pixel[9:5],   pixel[9:7],
                          pixel[4:0],   pixel[4:2]};
                la     = pixel[15] ? 8'h00 : 8'hFF;
                hit    = (pixel[15:0] == key_value[15:0]);
            end
            FMT_444: begin
                colour = {pixel[11:8], pixel[11:8],
                          pixel[7:4],  pixel[7:4],
                          pixel[3:0],  pixel[3:0]};
                la     = (|pixel[15:12]) ? 8'h00 : 8'hFF;
                hit    = (pixel[15:0] == key_value[15:0]);
            end
            default: begin
                colour = pixel[23:0];
                la     = pixel[31:24];
                hit    = (pixel[23:0] == key_value);
            end
        endcase
    end

    assign l = cfg_local_en  ? la           : 8'hFF;
    assign g = cfg_global_en ? global_alpha : 8'hFF;

    always_comb begin
        if (cfg_key_en && hit) alpha = 8'h00;
        else alpha = 8'(({8'd0, l} * {8'd0, g} + 16'd127) / 16'd255);
    end

endmodule

// File: rtl/osd_mix.sv
module osd_mix #(
    parameter int CH_W = 8,
    parameter int N_CH = 3,
    localparam int AW  = 2 * CH_W + 1
) (
    input  logic [N_CH*CH_W-1:0] ovl,
    input  logic [N_CH*CH_W-1:0] vid,
    input  logic [CH_W-1:0]      alpha,
    output logic [N_CH*CH_W-1:0] mixed
);

    localparam logic [CH_W-1:0] FULL = '1;

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        logic [CH_W-1:0] o, v;
        assign o = ovl[c*CH_W +: CH_W];
        assign v = vid[c*CH_W +: CH_W];
        assign mixed[c*CH_W +: CH_W] =
            CH_W'((AW'(o) * AW'(alpha) + AW'(v) * AW'(FULL - alpha)
                   + AW'(FULL >> 1)) / AW'(FULL));
    end

endmodule

// File: rtl/osd_blend.sv
module osd_blend
    import osd_blend_pkg::*;
#(
    parameter int PAL_DEPTH = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  cfg_mode,
    input  logic [1:0]  cfg_bpp,
    input  logic        cfg_key_en,
    input  logic        cfg_local_en,
    input  logic        cfg_global_en,
    input  logic [23:0] key_value,
    input  logic [7:0]  global_alpha,
    input  logic        pal_idx_wr,
    input  logic        pal_data_wr,
    input  logic [31:0] pal_wdata,
    input  logic        in_valid,
    input  logic [31:0] ovl_pixel,
    input  logic [23:0] vid_pixel,
    output logic        out_valid,
    output logic [23:0] out_pixel
);

    localparam int IDX_W = $clog2(PAL_DEPTH);

    logic [31:0] pal_word;
    rgb_t        u_colour, s1_colour;
    logic [7:0]  u_alpha, s1_alpha;
    logic [23:0] s1_vid, mix_out;
    logic        s1_valid;

    osd_palette #(.DEPTH(PAL_DEPTH), .WORD_W(32)) u_pal (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx_wr  (pal_idx_wr),
        .data_wr (pal_data_wr),
        .wdata   (pal_wdata),
        .rd_idx  (ovl_pixel[IDX_W-1:0]),
        .rd_word (pal_word)
    );

    osd_unpack u_unp (
        .cfg_mode      (cfg_mode),
        .cfg_bpp       (cfg_bpp),
        .cfg_key_en    (cfg_key_en),
        .cfg_local_en  (cfg_local_en),
        .cfg_global_en (cfg_global_en),
        .key_value     (key_value),
        .global_alpha  (global_alpha),
        .pixel         (ovl_pixel),
        .pal_word      (pal_word),
        .colour        (u_colour),
        .alpha         (u_alpha)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_colour <= '0;
            s1_alpha  <= '0;
            s1_vid    <= '0;
        end else begin
            s1_valid  <= in_valid;
            s1_colour <= u_colour;
            s1_alpha  <= u_alpha;
            s1_vid    <= vid_pixel;
        end
    end

    osd_mix #(.CH_W(8), .N_CH(3)) u_mix (
        .ovl   (s1_colour),
        .vid   (s1_vid),
        .alpha (s1_alpha),
        .mixed (mix_out)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_pixel <= '0;
        end else begin
            out_valid <= s1_valid;
            out_pixel <= mix_out;
        end
    end

endmodule

// File: rtl/osd_blend_checker.sv
module osd_blend_checker
    import osd_blend_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  cfg_mode,
    input logic [1:0]  cfg_bpp,
    input logic        cfg_key_en,
    input logic        cfg_local_en,
    input logic        cfg_global_en,
    input logic [23:0] key_value,
    input logic [7:0]  global_alpha,
    input logic        in_valid,
    input logic [31:0] ovl_pixel,
    input logic [23:0] vid_pixel,
    input logic        out_valid,
    input logic [23:0] out_pixel
);

    // R2: result arrives after two edges
    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid);

    // R2: no pixel in, no pixel out
    p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ##1 !out_valid);

    // R3: opaque 32-bit ARGB with every control off passes the overlay colour
    p_opaque_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cfg_bpp == 2'b11 && cfg_mode == FMT_8888 &&
         !cfg_key_en && !cfg_local_en && !cfg_global_en)
        |=> ##1 (out_pixel == $past(ovl_pixel[23:0], 2)));

    // R9: a 16-bit key hit shows the video pixel
    p_key_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cfg_key_en && cfg_bpp != BOX_8 && cfg_mode == FMT_565 &&
         ovl_pixel[15:0] == key_value[15:0])
        |=> ##1 (out_pixel == $past(vid_pixel, 2)));

    // R10: global alpha of zero shows the video pixel
    p_global_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cfg_global_en && global_alpha == 8'd0)
        |=> ##1 (out_pixel == $past(vid_pixel, 2)));

endmodule

bind osd_blend osd_blend_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_mode      (cfg_mode),
    .cfg_bpp       (cfg_bpp),
    .cfg_key_en    (cfg_key_en),
    .cfg_local_en  (cfg_local_en),
    .cfg_global_en (cfg_global_en),
    .key_value     (key_value),
    .global_alpha  (global_alpha),
    .in_valid      (in_valid),
    .ovl_pixel     (ovl_pixel),
    .vid_pixel     (vid_pixel),
    .out_valid     (out_valid),
    .out_pixel     (out_pixel)
);

// File: tb/osd_blend_test.sv
`timescale 1ns/1ps
module osd_blend_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_mode = 3'd4;
    logic [1:0]  cfg_bpp = 2'b11;
    logic        cfg_key_en = 1'b0;
    logic        cfg_local_en = 1'b0;
    logic        cfg_global_en = 1'b0;
    logic [23:0] key_value = '0;
    logic [7:0]  global_alpha = 8'hFF;
    logic        pal_idx_wr = 1'b0;
    logic        pal_data_wr = 1'b0;
    logic [31:0] pal_wdata = '0;
    logic        in_valid = 1'b0;
    logic [31:0] ovl_pixel = '0;
    logic [23:0] vid_pixel = '0;
    logic        out_valid;
    logic [23:0] out_pixel;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    osd_blend uut (.*);

    function automatic logic [7:0] w5(input logic [4:0] x); return {x, x[4:2]}; endfunction
    function automatic logic [7:0] w6(input logic [5:0] x); return {x, x[5:4]}; endfunction
    function automatic logic [7:0] w4(input logic [3:0] x); return {x, x}; endfunction

    function automatic logic [7:0] amul(input int l, input int g);
        return 8'((l * g + 127) / 255);
    endfunction

    function automatic logic [23:0] mix(input logic [23:0] o, input logic [23:0] v, input int a);
        logic [23:0] r;
        for (int c = 0; c < 3; c++)
            r[c*8 +: 8] = 8'((int'(o[c*8 +: 8]) * a + int'(v[c*8 +: 8]) * (255 - a) + 127) / 255);
        return r;
    endfunction

    task automatic check_val(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic configure(input logic [1:0] bpp, input logic [2:0] mode,
                             input logic k, input logic l, input logic g, input logic [7:0] ga);
        @(negedge clk);
        cfg_bpp = bpp; cfg_mode = mode; cfg_key_en = k;
        cfg_local_en = l; cfg_global_en = g; global_alpha = ga;
    endtask

    task automatic blend(input string req, input logic [31:0] ovl, input logic [23:0] vid,
                         input logic [23:0] exp);
        @(negedge clk);
        ovl_pixel = ovl; vid_pixel = vid; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check_val("R2", {31'd0, out_valid}, 32'd0);
        @(negedge clk);
        check_val("R2", {31'd0, out_valid}, 32'd1);
        check_val(req, {8'd0, out_pixel}, {8'd0, exp});
    endtask

    task automatic pal_index(input logic [7:0] idx);
        @(negedge clk); pal_wdata = {24'd0, idx}; pal_idx_wr = 1'b1;
        @(negedge clk); pal_idx_wr = 1'b0;
    endtask

    task automatic pal_data(input logic [31:0] w);
        @(negedge clk); pal_wdata = w; pal_data_wr = 1'b1;
        @(negedge clk); pal_data_wr = 1'b0;
    endtask

    task automatic t_reset_r1();
        check_val("R1", {31'd0, out_valid}, 32'd0);
        check_val("R1", {8'd0, out_pixel}, 32'd0);
    endtask

    task automatic t_argb_r3();
        configure(2'b11, 3'd4, 0, 0, 0, 8'hFF);
        blend("R3", 32'h80C04020, 24'h102030, 24'hC04020);
        configure(2'b11, 3'd4, 0, 1, 0, 8'hFF);
        blend("R3", 32'h80C04020, 24'h102030, mix(24'hC04020, 24'h102030, 128));
    endtask

    task automatic t_565_r4();
        configure(2'b10, 3'd1, 0, 1, 0, 8'hFF);
        blend("R4", 32'h0000A5B3, 24'h000000, {w5(5'b10100), w6(6'b101101), w5(5'b10011)});
    endtask

    task automatic t_555_r5();
        configure(2'b10, 3'd2, 0, 1, 0, 8'hFF);
        blend("R5", 32'h00007ABC, 24'h0F0F0F, {w5(5'b11110), w5(5'b10101), w5(5'b11100)});
        blend("R5", 32'h0000FABC, 24'h0F0F0F, 24'h0F0F0F);
    endtask

    task automatic t_444_r6();
        configure(2'b10, 3'd3, 0, 1, 0, 8'hFF);
        blend("R6", 32'h00000ABC, 24'h123456, {w4(4'hA), w4(4'hB), w4(4'hC)});
        blend("R6", 32'h00001ABC, 24'h123456, 24'h123456);
        configure(2'b11, 3'd3, 0, 1, 0, 8'hFF);
        blend("R7", 32'hFFFF0ABC, 24'h123456, 24'hAABBCC);
    endtask

    task automatic t_palette_r8();
        pal_index(8'd0);
        pal_data(32'hFF_445566);
        pal_data(32'hFF_FFFFFF);           // stray write in PAL_IDLE
        configure(2'b01, 3'd4, 0, 0, 0, 8'hFF);
        blend("R8", 32'hABCDEF00, 24'h000000, 24'h445566);
        pal_index(8'd7);
        pal_data(32'h40_112233);
        configure(2'b01, 3'd2, 0, 1, 0, 8'hFF);
        blend("R7", 32'hABCDEF07, 24'h808080, mix(24'h112233, 24'h808080, 64));
        configure(2'b11, 3'd0, 0, 1, 0, 8'hFF);
        blend("R8", 32'h00000007, 24'h808080, mix(24'h112233, 24'h808080, 64));
    endtask

    task automatic t_key_r9();
        key_value = 24'h00A5B3;
        configure(2'b11, 3'd1, 1, 0, 0, 8'hFF);
        blend("R9", 32'h1234A5B3, 24'h314159, 24'h314159);
        blend("R9", 32'h0000A5B2, 24'h314159, {w5(5'b10100), w6(6'b101101), w5(5'b10010)});
        key_value = 24'h445566;
        configure(2'b11, 3'd4, 1, 0, 0, 8'hFF);
        blend("R9", 32'hFF445566, 24'h271828, 24'h271828);
        key_value = 24'h000007;
        configure(2'b01, 3'd0, 1, 0, 0, 8'hFF);
        blend("R9", 32'h00000007, 24'h271828, 24'h271828);
    endtask

    task automatic t_global_r10();
        key_value = 24'h000000;
        configure(2'b11, 3'd4, 0, 1, 1, 8'h80);
        blend("R10", 32'h80C04020, 24'h102030, mix(24'hC04020, 24'h102030, int'(amul(128, 128))));
        configure(2'b11, 3'd4, 0, 0, 1, 8'h00);
        blend("R10", 32'hFFC04020, 24'h102030, 24'h102030);
        configure(2'b11, 3'd4, 0, 0, 1, 8'hC8);
        blend("R10", 32'h00FF0000, 24'h0000FF, mix(24'hFF0000, 24'h0000FF, 200));
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        t_reset_r1();
        @(negedge clk); rst_n = 1'b1;
        t_reset_r1();
        t_argb_r3();
        t_565_r4();
        t_555_r5();
        t_444_r6();
        t_palette_r8();
        t_key_r9();
        t_global_r10();
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule